// File: doc/BRIEF.md
# Coprocessor Context Save/Restore Controller

This block is the slave-side register port that a host processor uses to save and restore the context of an attached coprocessor. The host makes single-cycle 16-bit reads and writes at byte offsets. Each access is decoded against a small protocol state that records which access the controller expects next.

A read of the save register returns a format word. That word describes the context: null, not ready yet, idle, or busy with a suspended operation. A write of the restore register submits a format word for checking, and the host then reads the result back. Frame words move through the operand register in both directions, in 16-bit halves, from and to an internal frame buffer.

A modelled execution unit stands in for the arithmetic core. Command writes start it, save reads suspend it, and restore writes and aborts halt it. An access that breaks the expected order is ignored and sets a sticky error flag. An abort through the control register clears the flag.

Top module: `ctx_xfer_ctrl`

## Requirements
- R1: After reset the error flag, `exec_busy`, `exec_held`, `ctx_live` and `xfer_active` are all 0, and a save read returns the null word 0x0000.
- R2: A save read with a null context and an idle unit returns 0x0000 and starts no transfer. A following command or condition write (offset 0x0A / 0x0E) is accepted without error.
- R3: A save read while the unit runs suspends it: `exec_busy` falls and `exec_held` rises after the access edge. The read returns the not-ready word 0x0100, and further save reads return 0x0100 until SUSP_LAT cycles have passed since the suspension. After that, a save read returns the busy word {0x1F, BUSY_LEN} (0x1FB4 by default).
- R4: A save read with a live context and an idle unit returns 0x1F18. After an idle or busy word, exactly 2×length operand reads (offset 0x10) return the buffer halves in order. After the last one, `xfer_active`, `exec_held` and `ctx_live` are 0, and the next save read returns 0x0000.
- R5: A save read (offset 0x04) during any frame transfer returns 0x0200, sets the error flag and ends the transfer.
- R6: A restore write (offset 0x06) halts the unit by the next cycle. The restore read that follows returns the written word if it is 0x0000, 0x1F18 or the busy word, and returns 0x0200 otherwise.
- R7: After a valid idle or busy echo, 2×length operand writes fill the buffer in order. The last write makes `ctx_live` 1, and a busy frame also restarts the unit. A null echo makes `ctx_live` 0 and needs no operand access.
- R8: A control write (offset 0x02) with bit 0 set clears the error flag, halts the unit and ends any transfer, so that a command write is accepted next. A control write with bit 0 clear changes nothing.
- R9: Writes to the operation-word offset 0x08 change no state and never set the error flag.
- R10: A command write starts the unit, which keeps `exec_busy` high for exactly EXEC_CYCLES cycles and makes `ctx_live` 1.
- R11: An access that does not match the expected next access is ignored and sets the error flag. Only an abort or a reset clears the flag.
- R12: A read of an unmapped or write-only offset returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Host access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| exec_busy | output | 1 | Modelled unit is running |
| exec_held | output | 1 | Modelled unit is suspended |
| ctx_live | output | 1 | Context is not null |
| proto_err | output | 1 | Sticky protocol-violation flag |
| xfer_active | output | 1 | Frame transfer in progress |

## Verification
The bench issues back-to-back save reads right after a suspension. A design that settled the suspension at once would hand out a busy word early, and one that never settled would repeat the not-ready word forever. It cuts a save stream short with a save read, which catches a design that accepts the illegal read or keeps streaming. It submits a bad restore word and then a command, which catches a design that skips validation or lets a command through before the abort. It also checks frame contents half by half after a restore and save round trip, and counts the exact run length of a command, so an off-by-one in the stream index or the cycle counter shows up as a wrong value.

// File: rtl/ctx_pkg.sv
// Shared constants and types for the context save/restore controller.
// Assumes byte offsets fit in five address bits.
package ctx_pkg;
    localparam logic [4:0] OFF_CTRL = 5'h02;
    localparam logic [4:0] OFF_SAVE = 5'h04;
    localparam logic [4:0] OFF_RST  = 5'h06;
    localparam logic [4:0] OFF_OPW  = 5'h08;
    localparam logic [4:0] OFF_CMD  = 5'h0A;
    localparam logic [4:0] OFF_COND = 5'h0E;
    localparam logic [4:0] OFF_OPND = 5'h10;

    localparam logic [15:0] FW_NULL     = 16'h0000;
    localparam logic [15:0] FW_NOTREADY = 16'h0100;
    localparam logic [15:0] FW_INVALID  = 16'h0200;
    localparam logic [7:0]  FW_VER      = 8'h1F;

    // Expected-next-access state
    typedef enum logic [2:0] {
        EXP_ANY,        // command, condition, save or restore
        EXP_SAVE_AGAIN, // another save read after not-ready
        EXP_SAVE_XFER,  // operand reads of a saved frame
        EXP_RST_CHECK,  // restore read for the verdict
        EXP_RST_XFER,   // operand writes of a restored frame
        EXP_ABORT       // waiting for an abort
    } exp_e;
endpackage

// File: rtl/ctx_exec.sv
// Modelled execution unit: runs for a fixed number of cycles after a start,
// can be suspended (settling takes SUSP_LAT cycles), halted or resumed,
// and tracks whether the coprocessor holds a non-null context.
// Assumes the sequencer never asserts start and suspend together.
module ctx_exec #(
    parameter int EXEC_CYCLES = 16,
    parameter int SUSP_LAT    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic suspend,
    input  logic halt,
    input  logic resume,
    input  logic ctx_drop,
    input  logic ctx_load,
    output logic running,
    output logic suspended,
    output logic settled,
    output logic ctx_valid
);
    localparam int CW = $clog2(EXEC_CYCLES + 1);
    localparam int SW = $clog2(SUSP_LAT + 1);

    logic [CW-1:0] run_cnt;
    logic [SW-1:0] sus_cnt;

    // Run/suspend state and the remaining-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            suspended <= 1'b0;
            run_cnt   <= '0;
        end else if (halt) begin
            running   <= 1'b0;
            suspended <= 1'b0;
        end else if (start || resume) begin
            running   <= 1'b1;
            suspended <= 1'b0;
            run_cnt   <= CW'(EXEC_CYCLES);
        end else if (suspend) begin
            running   <= 1'b0;
            suspended <= 1'b1;
        end else if (running) begin
            run_cnt <= run_cnt - 1'b1;
            if (run_cnt == CW'(1)) running <= 1'b0;
        end
    end

    // Settling counter that starts when the unit is suspended
    always_ff @(posedge clk) begin
        if (!rst_n)                  sus_cnt <= '0;
        else if (suspend && !halt)   sus_cnt <= SW'(SUSP_LAT);
        else if (sus_cnt != '0)      sus_cnt <= sus_cnt - 1'b1;
    end

    assign settled = suspended && (sus_cnt == '0);

    // Context presence flag
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctx_valid <= 1'b0;
        else if (ctx_drop)          ctx_valid <= 1'b0;
        else if (start || ctx_load) ctx_valid <= 1'b1;
    end

    assert_halt_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !running && !suspended);
    assert_suspend_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !halt && !start && !resume) |=> suspended && !running);
    assert_run_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(running && suspended));
endmodule

// File: rtl/ctx_fmt.sv
// Format-word logic: picks the word a save read returns from the unit and
// transfer state, and validates a word submitted through the restore register.
// Purely combinational.
module ctx_fmt
    import ctx_pkg::*;
#(
    parameter int IDLE_LEN = 24,
    parameter int BUSY_LEN = 180
) (
    input  logic        run,
    input  logic        held,
    input  logic        held_settled,
    input  logic        ctx_valid,
    input  logic        in_xfer,
    input  logic [15:0] chk_word,
    output logic [15:0] save_word,
    output logic        chk_ok,
    output logic [15:0] idle_word,
    output logic [15:0] busy_word
);
    assign idle_word = {FW_VER, 8'(IDLE_LEN)};
    assign busy_word = {FW_VER, 8'(BUSY_LEN)};

    // Save-read word selection, transfer state first
    always_comb begin
        if (in_xfer)        save_word = FW_INVALID;
        else if (run)       save_word = FW_NOTREADY;
        else if (held)      save_word = held_settled ? busy_word : FW_NOTREADY;
        else if (ctx_valid) save_word = idle_word;
        else                save_word = FW_NULL;
    end

    // Restore validation: only the three frame kinds are accepted
    assign chk_ok = (chk_word == FW_NULL) || (chk_word == idle_word) ||
                    (chk_word == busy_word);
endmodule

// File: rtl/ctx_frame_buf.sv
// Frame buffer of 16-bit halves with a shared streaming index.
// Assumes the sequencer clears the index before each transfer and never
// steps past DEPTH.
module ctx_frame_buf #(
    parameter int DEPTH = 360,
    parameter int IW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          we,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output logic [IW-1:0] idx
);
    localparam int AW = $clog2(DEPTH);

    logic [15:0] mem [DEPTH];

    // Streaming index
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (clr)  idx <= '0;
        else if (step) idx <= idx + 1'b1;
    end

    // Frame storage write port
    always_ff @(posedge clk) begin
        if (we) mem[idx[AW-1:0]] <= wdata;
    end

    assign rdata = mem[idx[AW-1:0]];

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step || we) |-> (idx < IW'(DEPTH)));
endmodule

// File: rtl/ctx_seq.sv
// Protocol sequencer: decodes host accesses, keeps the expected-next-access
// state, drives the execution model and frame buffer, and holds the sticky
// violation flag and the last restore verdict.
// Assumes one access per cycle and bus_valid low between accesses.
module ctx_seq
    import ctx_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int IW     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              ex_run,
    input  logic [15:0]       save_word,
    input  logic              chk_ok,
    input  logic [15:0]       busy_word,
    input  logic [15:0]       buf_rdata,
    input  logic [IW-1:0]     buf_idx,
    output logic              ex_start,
    output logic              ex_susp,
    output logic              ex_halt,
    output logic              ex_resume,
    output logic              ctx_drop,
    output logic              ctx_load,
    output logic              buf_clr,
    output logic              buf_step,
    output logic              buf_we,
    output logic              in_xfer,
    output logic              proto_err
);
    exp_e        exp_q, exp_n;
    logic [IW-1:0] len_q, len_n;
    logic [15:0] verdict_q;
    logic        verdict_ld;
    logic        viol;

    logic rd, wr;
    logic hit_ctrl, hit_save, hit_rst, hit_opw, hit_cmd, hit_cond, hit_opnd;
    logic is_abort, last_half;

    assign rd = bus_valid && !bus_write;
    assign wr = bus_valid &&  bus_write;

    // Offset decode
    always_comb begin
        hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_save = (bus_addr == ADDR_W'(OFF_SAVE));
        hit_rst  = (bus_addr == ADDR_W'(OFF_RST));
        hit_opw  = (bus_addr == ADDR_W'(OFF_OPW));
        hit_cmd  = (bus_addr == ADDR_W'(OFF_CMD));
        hit_cond = (bus_addr == ADDR_W'(OFF_COND));
        hit_opnd = (bus_addr == ADDR_W'(OFF_OPND));
    end

    assign in_xfer   = (exp_q == EXP_SAVE_XFER) || (exp_q == EXP_RST_XFER);
    assign is_abort  = wr && hit_ctrl && bus_wdata[0];
    assign last_half = (buf_idx == len_q - 1'b1);

    // Next expected access and the control pulses of this access
    always_comb begin
        exp_n      = exp_q;
        len_n      = len_q;
        viol       = 1'b0;
        verdict_ld = 1'b0;
        ex_start   = 1'b0;
        ex_susp    = 1'b0;
        ex_halt    = 1'b0;
        ex_resume  = 1'b0;
        ctx_drop   = 1'b0;
        ctx_load   = 1'b0;
        buf_clr    = 1'b0;
        buf_step   = 1'b0;
        buf_we     = 1'b0;
        if (is_abort) begin
            exp_n   = EXP_ANY;
            ex_halt = 1'b1;
            buf_clr = 1'b1;
        end else if (rd && hit_save) begin
            if (in_xfer) begin
                exp_n   = EXP_ABORT;
                viol    = 1'b1;
                buf_clr = 1'b1;
            end else if (save_word == FW_NOTREADY) begin
                ex_susp = ex_run;
                exp_n   = EXP_SAVE_AGAIN;
            end else if (save_word == FW_NULL) begin
                exp_n = EXP_ANY;
            end else begin
                exp_n   = EXP_SAVE_XFER;
                len_n   = IW'({save_word[7:0], 1'b0});
                buf_clr = 1'b1;
            end
        end else if (wr && hit_rst) begin
            if (exp_q == EXP_ANY || exp_q == EXP_RST_CHECK) begin
                ex_halt    = 1'b1;
                verdict_ld = 1'b1;
                exp_n      = EXP_RST_CHECK;
            end else begin
                viol = 1'b1;
            end
        end else if (rd && hit_rst) begin
            if (exp_q != EXP_RST_CHECK) begin
                viol = 1'b1;
            end else if (verdict_q == FW_INVALID) begin
                exp_n = EXP_ABORT;
            end else if (verdict_q == FW_NULL) begin
                exp_n    = EXP_ANY;
                ctx_drop = 1'b1;
            end else begin
                exp_n   = EXP_RST_XFER;
                len_n   = IW'({verdict_q[7:0], 1'b0});
                buf_clr = 1'b1;
            end
        end else if (rd && hit_opnd) begin
            if (exp_q == EXP_SAVE_XFER) begin
                buf_step = 1'b1;
                if (last_half) begin
                    exp_n    = EXP_ANY;
                    ex_halt  = 1'b1;
                    ctx_drop = 1'b1;
                end
            end else begin
                viol = 1'b1;
            end
        end else if (wr && hit_opnd) begin
            if (exp_q == EXP_RST_XFER) begin
                buf_we   = 1'b1;
                buf_step = 1'b1;
                if (last_half) begin
                    exp_n     = EXP_ANY;
                    ctx_load  = 1'b1;
                    ex_resume = (verdict_q == busy_word);
                end
            end else begin
                viol = 1'b1;
            end
        end else if (wr && (hit_cmd || hit_cond)) begin
            if (exp_q == EXP_ANY) ex_start = hit_cmd;
            else                  viol     = 1'b1;
        end
    end

    // Protocol state, transfer length and restore verdict registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q     <= EXP_ANY;
            len_q     <= '0;
            verdict_q <= FW_NULL;
        end else begin
            exp_q <= exp_n;
            len_q <= len_n;
            if (verdict_ld) verdict_q <= chk_ok ? bus_wdata : FW_INVALID;
        end
    end

    // Sticky violation flag
    always_ff @(posedge clk) begin
        if (!rst_n)        proto_err <= 1'b0;
        else if (is_abort) proto_err <= 1'b0;
        else if (viol)     proto_err <= 1'b1;
    end

    // Read data mux for the access cycle
    always_comb begin
        bus_rdata = 16'h0000;
        if (rd) begin
            if (hit_save)
                bus_rdata = save_word;
            else if (hit_rst && exp_q == EXP_RST_CHECK)
                bus_rdata = verdict_q;
            else if (hit_opnd && exp_q == EXP_SAVE_XFER)
                bus_rdata = buf_rdata;
        end
    end

    assert_save_in_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_save && in_xfer) |=> proto_err && !in_xfer);
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && !is_abort) |=> proto_err);
    assert_opword_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_opw) |=> $stable(proto_err) && $stable(exp_q) && $stable(buf_idx));
    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_abort |=> !proto_err && (exp_q == EXP_ANY));
endmodule

// File: rtl/ctx_xfer_ctrl.sv
// Top of the coprocessor context save/restore controller. Joins the
// sequencer, format-word logic, execution model and frame buffer.
// Assumes BUSY_LEN >= IDLE_LEN and BUSY_LEN <= 255.
module ctx_xfer_ctrl #(
    parameter int ADDR_W      = 5,
    parameter int IDLE_LEN    = 24,
    parameter int BUSY_LEN    = 180,
    parameter int EXEC_CYCLES = 16,
    parameter int SUSP_LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              exec_busy,
    output logic              exec_held,
    output logic              ctx_live,
    output logic              proto_err,
    output logic              xfer_active
);
    localparam int DEPTH = 2 * BUSY_LEN;
    localparam int IW    = $clog2(DEPTH) + 1;

    logic ex_start, ex_susp, ex_halt, ex_resume, ctx_drop, ctx_load;
    logic ex_settled, chk_ok;
    logic buf_clr, buf_step, buf_we;
    logic [15:0] save_word, idle_word, busy_word, buf_rdata;
    logic [IW-1:0] buf_idx;

    ctx_seq #(.ADDR_W(ADDR_W), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ex_run(exec_busy), .save_word(save_word), .chk_ok(chk_ok),
        .busy_word(busy_word), .buf_rdata(buf_rdata), .buf_idx(buf_idx),
        .ex_start(ex_start), .ex_susp(ex_susp), .ex_halt(ex_halt),
        .ex_resume(ex_resume), .ctx_drop(ctx_drop), .ctx_load(ctx_load),
        .buf_clr(buf_clr), .buf_step(buf_step), .buf_we(buf_we),
        .in_xfer(xfer_active), .proto_err(proto_err)
    );

    ctx_fmt #(.IDLE_LEN(IDLE_LEN), .BUSY_LEN(BUSY_LEN)) u_fmt (
        .run(exec_busy), .held(exec_held), .held_settled(ex_settled),
        .ctx_valid(ctx_live), .in_xfer(xfer_active), .chk_word(bus_wdata),
        .save_word(save_word), .chk_ok(chk_ok),
        .idle_word(idle_word), .busy_word(busy_word)
    );

    ctx_exec #(.EXEC_CYCLES(EXEC_CYCLES), .SUSP_LAT(SUSP_LAT)) u_exec (
        .clk(clk), .rst_n(rst_n),
        .start(ex_start), .suspend(ex_susp), .halt(ex_halt),
        .resume(ex_resume), .ctx_drop(ctx_drop), .ctx_load(ctx_load),
        .running(exec_busy), .suspended(exec_held), .settled(ex_settled),
        .ctx_valid(ctx_live)
    );

    ctx_frame_buf #(.DEPTH(DEPTH), .IW(IW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr(buf_clr), .step(buf_step), .we(buf_we),
        .wdata(bus_wdata), .rdata(buf_rdata), .idx(buf_idx)
    );
endmodule

// File: tb/ctx_xfer_ctrl_tb.sv
// Directed bench for the context save/restore controller.
module ctx_xfer_ctrl_tb;
    localparam int IDLE_LEN = 24;
    localparam int BUSY_LEN = 180;
    localparam int EXEC_CYC = 16;
    localparam int SUSP_LAT = 4;
    localparam logic [4:0] A_CTRL = 5'h02, A_SAVE = 5'h04, A_RST = 5'h06,
        A_OPW = 5'h08, A_CMD = 5'h0A, A_COND = 5'h0E, A_OPND = 5'h10;
    localparam logic [15:0] W_IDLE = 16'h1F18, W_BUSY = 16'h1FB4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic exec_busy, exec_held, ctx_live, proto_err, xfer_active;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctx_xfer_ctrl #(.IDLE_LEN(IDLE_LEN), .BUSY_LEN(BUSY_LEN),
        .EXEC_CYCLES(EXEC_CYC), .SUSP_LAT(SUSP_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .exec_busy(exec_busy), .exec_held(exec_held), .ctx_live(ctx_live),
        .proto_err(proto_err), .xfer_active(xfer_active));

    function automatic logic [15:0] pat(int k);
        return 16'hA500 ^ 16'(k * 16'h0137);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_valid = 1'b0;
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1 bus_valid = 1'b0;
    endtask

    task automatic do_abort();
        wr(A_CTRL, 16'h0001);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 err", 16'(proto_err), 0);
        check("R1 busy", 16'(exec_busy), 0);
        check("R1 held", 16'(exec_held), 0);
        check("R1 ctx", 16'(ctx_live), 0);
        check("R1 xfer", 16'(xfer_active), 0);
        rd(A_SAVE, d); check("R1 save", d, 16'h0000);
    endtask

    task automatic t_null_save();
        logic [15:0] d;
        rd(A_SAVE, d); check("R2 null word", d, 16'h0000);
        check("R2 no xfer", 16'(xfer_active), 0);
        wr(A_COND, 16'h0005); check("R2 cond ok", 16'(proto_err), 0);
    endtask

    task automatic t_ignored();
        logic [15:0] d;
        wr(A_OPW, 16'hF200);
        check("R9 no err", 16'(proto_err), 0);
        check("R9 no start", 16'(exec_busy), 0);
        rd(A_CMD, d); check("R12 wo read", d, 0);
        rd(5'h1E, d); check("R12 unmapped", d, 0);
        check("R12 no err", 16'(proto_err), 0);
        wr(A_CTRL, 16'h0000); check("R8 ctrl nop", 16'(proto_err), 0);
    endtask

    task automatic t_restore_idle();
        logic [15:0] d;
        wr(A_RST, W_IDLE); rd(A_RST, d); check("R6 idle echo", d, W_IDLE);
        check("R7 xfer on", 16'(xfer_active), 1);
        for (int k = 0; k < 2*IDLE_LEN; k++) wr(A_OPND, pat(k));
        check("R7 ctx live", 16'(ctx_live), 1);
        check("R7 xfer off", 16'(xfer_active), 0);
        check("R7 no err", 16'(proto_err), 0);
    endtask

    task automatic t_save_idle();
        logic [15:0] d;
        int bad = 0;
        rd(A_SAVE, d); check("R4 idle word", d, W_IDLE);
        for (int k = 0; k < 2*IDLE_LEN; k++) begin
            rd(A_OPND, d);
            if (d !== pat(k)) begin
                bad++;
                if (bad == 1) check("R4 frame half", d, pat(k));
            end
        end
        check("R4 frame halves bad", 16'(bad), 0);
        check("R4 ctx dropped", 16'(ctx_live), 0);
        check("R4 xfer off", 16'(xfer_active), 0);
        rd(A_SAVE, d); check("R4 null after", d, 16'h0000);
    endtask

    task automatic t_cmd_len();
        int n = 0;
        wr(A_CMD, 16'h4000);
        check("R10 ctx", 16'(ctx_live), 1);
        while (exec_busy && n < 1000) begin n++; @(posedge clk); #1; end
        check("R10 run cycles", 16'(n), 16'(EXEC_CYC));
    endtask

    task automatic t_suspend_busy();
        logic [15:0] d;
        wr(A_CMD, 16'h4001);
        rd(A_SAVE, d); check("R3 first notready", d, 16'h0100);
        check("R3 stopped", 16'(exec_busy), 0);
        check("R3 held", 16'(exec_held), 1);
        rd(A_SAVE, d); check("R3 again notready", d, 16'h0100);
        repeat (SUSP_LAT) @(posedge clk);
        rd(A_SAVE, d); check("R3 busy word", d, W_BUSY);
        for (int k = 0; k < 2*BUSY_LEN - 1; k++) rd(A_OPND, d);
        check("R4 busy xfer on", 16'(xfer_active), 1);
        rd(A_OPND, d);
        check("R4 busy xfer off", 16'(xfer_active), 0);
        check("R4 held cleared", 16'(exec_held), 0);
        check("R4 busy no err", 16'(proto_err), 0);
    endtask

    task automatic t_cut_stream();
        logic [15:0] d;
        t_restore_idle();
        rd(A_SAVE, d); check("R4 idle word 2", d, W_IDLE);
        repeat (5) rd(A_OPND, d);
        rd(A_SAVE, d); check("R5 invalid word", d, 16'h0200);
        check("R5 err", 16'(proto_err), 1);
        check("R5 xfer ended", 16'(xfer_active), 0);
        rd(A_OPND, d); check("R11 sticky", 16'(proto_err), 1);
        do_abort(); check("R8 abort clears", 16'(proto_err), 0);
    endtask

    task automatic t_bad_restore();
        logic [15:0] d;
        wr(A_CMD, 16'h4002);
        wr(A_RST, 16'h1234); check("R6 halted", 16'(exec_busy), 0);
        rd(A_RST, d); check("R6 invalid verdict", d, 16'h0200);
        wr(A_CMD, 16'h4003);
        check("R11 cmd refused err", 16'(proto_err), 1);
        check("R11 cmd refused run", 16'(exec_busy), 0);
        do_abort(); check("R8 err clear", 16'(proto_err), 0);
        wr(A_CMD, 16'h4004); check("R8 cmd after abort", 16'(exec_busy), 1);
        do_abort(); check("R8 abort halts", 16'(exec_busy), 0);
    endtask

    task automatic t_restore_busy_null();
        logic [15:0] d;
        wr(A_RST, W_BUSY); rd(A_RST, d); check("R6 busy echo", d, W_BUSY);
        for (int k = 0; k < 2*BUSY_LEN; k++) wr(A_OPND, pat(k + 7));
        check("R7 busy resumes", 16'(exec_busy), 1);
        wr(A_RST, 16'h0000); check("R6 stop on write", 16'(exec_busy), 0);
        rd(A_RST, d); check("R6 null echo", d, 16'h0000);
        check("R7 null ctx", 16'(ctx_live), 0);
        check("R7 null no xfer", 16'(xfer_active), 0);
    endtask

    task automatic t_out_of_order();
        logic [15:0] d;
        rd(A_OPND, d); check("R11 opnd read data", d, 0);
        check("R11 flag", 16'(proto_err), 1);
        wr(A_CTRL, 16'h0002); check("R8 nonabort keeps", 16'(proto_err), 1);
        wr(A_OPW, 16'h0000); check("R9 no clear", 16'(proto_err), 1);
        do_abort(); check("R11 abort clears", 16'(proto_err), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_null_save();
        t_ignored();
        t_restore_idle();
        t_save_idle();
        t_cmd_len();
        t_suspend_busy();
        t_cut_stream();
        t_bad_restore();
        t_restore_busy_null();
        t_out_of_order();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule